// File: doc/BRIEF.md
# Unified Dispatch Queue with Oldest-First Issue

This block is the single scheduling pool of an out-of-order core. Already-renamed instructions of every functional-unit class land in it in program order. Each entry carries an operation class, two source tags with ready flags, a destination tag and a program-order sequence number.

Every cycle the block does four things. It appends up to one and a half issue-widths of new instructions behind the youngest entry. It watches the result tags broadcast by the execution units and marks the matching sources ready. It walks the entries from oldest to youngest and grants issue greedily, within a total width and a separate budget for each class. On a branch mispredict it discards every entry younger than the branch.

The storage is kept compacted, so a slot's position is its age. Index 0 always holds the oldest surviving instruction. Entries that issue or are flushed close up at the next clock edge.

Top module: `dq_unified_issue`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is all zero, and `ins_full` is low whenever no more than DEPTH instructions are offered.
- R2: Valid insert lanes are appended behind the youngest entry in ascending lane order. Invalid lanes are skipped, even when they sit between valid ones. Up to ISSUE_W*3/2 lanes are accepted per cycle.
- R3: `ins_full` is high in a cycle when the free slots (DEPTH minus the occupancy at the start of the cycle) are fewer than the number of valid insert lanes. In that cycle no lane is accepted.
- R4: An entry is eligible for issue only when both of its source ready flags are set. A flag is set by the matching `ins_rdy` bit at insertion, or by a broadcast `wb_tag` equal to that source tag. A broadcast in the insertion cycle counts. A source made ready in cycle t can issue no earlier than cycle t+1.
- R5: Issue grants go to eligible entries strictly from oldest to youngest. Granted entries fill `iss_valid` slots contiguously from slot 0 in age order.
- R6: No more than ISSUE_W instructions issue in one cycle.
- R7: Class codes are 0 integer, 1 floating-point divide, 2 other floating-point, 3 memory and 4 control flow. The per-cycle caps are ISSUE_W, ISSUE_W/4, ISSUE_W/2, ISSUE_W/2 and ISSUE_W/4 for these classes. An eligible entry whose class budget is spent is passed over, and selection continues with younger entries whose class still has room.
- R8: An issued entry leaves the queue at the end of its issue cycle. Its slot counts as free for insertion from the next cycle.
- R9: While `flush_valid` is high, every entry whose sequence number is younger than `flush_seq` is removed. The comparison uses the sign of the modular difference. The flushing entry and all older entries stay. In that cycle nothing issues and all insert lanes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | INS_W | Insert lane valid, lane 0 oldest |
| ins_class | input | INS_W x 3 | Class code per lane |
| ins_src1 | input | INS_W x TAG_W | First source tag |
| ins_rdy1 | input | INS_W | First source already ready |
| ins_src2 | input | INS_W x TAG_W | Second source tag |
| ins_rdy2 | input | INS_W | Second source already ready |
| ins_dst | input | INS_W x TAG_W | Destination tag |
| ins_seq | input | INS_W x SEQ_W | Program-order sequence number |
| ins_full | output | 1 | Insertion refused this cycle |
| wb_valid | input | WB_N | Writeback broadcast valid |
| wb_tag | input | WB_N x TAG_W | Writeback broadcast tag |
| flush_valid | input | 1 | Mispredict flush request |
| flush_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| iss_valid | output | ISSUE_W | Issue slot valid, slot 0 oldest |
| iss_class | output | ISSUE_W x 3 | Class of issued instruction |
| iss_dst | output | ISSUE_W x TAG_W | Destination tag of issued instruction |
| iss_seq | output | ISSUE_W x SEQ_W | Sequence number of issued instruction |

## Verification
The bench targets the class-cap skip. In that case an older divide or branch that has lost its budget must not stall younger integer work. A design that stops at the first capped entry issues too few instructions, and one that ignores the cap issues too many of that class.

It also covers a wakeup that arrives in the same cycle as insertion, which a design that only wakes stored entries would leave asleep forever. Other targets are non-contiguous insert lanes, which a prefix-only design would misplace, and the exact point where a nearly full queue starts refusing. The last is a flush that arrives together with an insertion and with ready entries, where a wrong design would issue or keep younger work.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int TAG_W = 7;
    localparam int SEQ_W = 8;
    localparam int NCLS  = 5;

    typedef enum logic [2:0] {
        CL_INT  = 3'd0,
        CL_FDIV = 3'd1,
        CL_FP   = 3'd2,
        CL_MEM  = 3'd3,
        CL_CTRL = 3'd4
    } op_class_e;

    typedef struct packed {
        logic             vld;
        op_class_e        cls;
        logic [TAG_W-1:0] src1;
        logic             rdy1;
        logic [TAG_W-1:0] src2;
        logic             rdy2;
        logic [TAG_W-1:0] dst;
        logic [SEQ_W-1:0] seq;
    } dq_entry_t;

    // Per-cycle issue budget of one class for a given total width.
    function automatic int class_cap(input int c, input int iw);
        if (c == 0) return iw;
        if (c == 1) return iw / 4;
        if (c == 2) return iw / 2;
        if (c == 3) return iw / 2;
        if (c == 4) return iw / 4;
        return 0;
    endfunction

    // True when a is strictly younger than b in modular sequence space.
    function automatic logic seq_younger(input logic [SEQ_W-1:0] a,
                                         input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && (d[SEQ_W-1] == 1'b0);
    endfunction
endpackage

// File: rtl/dq_select.sv
module dq_select
    import dq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int ISSUE_W = 4
) (
    input  dq_entry_t          ent       [DEPTH],
    input  logic               enable,
    output logic [DEPTH-1:0]   pick,
    output logic [ISSUE_W-1:0] iss_valid,
    output dq_entry_t          iss_ent   [ISSUE_W]
);
    // Greedy walk from slot 0 (oldest) towards the youngest entry.
    always_comb begin
        int total;
        int used [NCLS];
        pick      = '0;
        iss_valid = '0;
        for (int s = 0; s < ISSUE_W; s++) iss_ent[s] = '0;
        total = 0;
        for (int c = 0; c < NCLS; c++) used[c] = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (enable && ent[i].vld && ent[i].rdy1 && ent[i].rdy2 &&
                total < ISSUE_W) begin
                for (int c = 0; c < NCLS; c++) begin
                    if (int'(ent[i].cls) == c && used[c] < class_cap(c, ISSUE_W)) begin
                        pick[i] = 1'b1;
                        for (int s = 0; s < ISSUE_W; s++) begin
                            if (s == total) begin
                                iss_valid[s] = 1'b1;
                                iss_ent[s]   = ent[i];
                            end
                        end
                        used[c] = used[c] + 1;
                        total   = total + 1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dq_compact.sv
module dq_compact
    import dq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int INS_W = 6,
    parameter int WB_N  = 4
) (
    input  dq_entry_t                    cur      [DEPTH],
    input  logic [DEPTH-1:0]             pick,
    input  logic                         flush_valid,
    input  logic [SEQ_W-1:0]             flush_seq,
    input  dq_entry_t                    ins_ent  [INS_W],
    input  logic                         ins_take,
    input  logic [WB_N-1:0]              wb_valid,
    input  logic [WB_N-1:0][TAG_W-1:0]   wb_tag,
    output dq_entry_t                    nxt      [DEPTH],
    output logic [$clog2(DEPTH+1)-1:0]   nxt_cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic dq_entry_t wake(input dq_entry_t e);
        dq_entry_t r;
        r = e;
        for (int w = 0; w < WB_N; w++) begin
            if (wb_valid[w] && wb_tag[w] == r.src1) r.rdy1 = 1'b1;
            if (wb_valid[w] && wb_tag[w] == r.src2) r.rdy2 = 1'b1;
        end
        return r;
    endfunction

    // Survivors keep their order; accepted lanes follow behind them.
    always_comb begin
        int        wp;
        dq_entry_t e;
        for (int d = 0; d < DEPTH; d++) nxt[d] = '0;
        wp = 0;
        e  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cur[i].vld && !pick[i] &&
                !(flush_valid && seq_younger(cur[i].seq, flush_seq))) begin
                e = wake(cur[i]);
                for (int d = 0; d < DEPTH; d++) if (d == wp) nxt[d] = e;
                wp = wp + 1;
            end
        end
        for (int l = 0; l < INS_W; l++) begin
            if (ins_take && ins_ent[l].vld) begin
                e = wake(ins_ent[l]);
                for (int d = 0; d < DEPTH; d++) if (d == wp) nxt[d] = e;
                wp = wp + 1;
            end
        end
        nxt_cnt = CNT_W'(wp);
    end
endmodule

// File: rtl/dq_unified_issue.sv
module dq_unified_issue
    import dq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int ISSUE_W = 4,
    parameter int WB_N    = 4,
    parameter int INS_W   = ISSUE_W + ISSUE_W / 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [INS_W-1:0]               ins_valid,
    input  logic [INS_W-1:0][2:0]          ins_class,
    input  logic [INS_W-1:0][TAG_W-1:0]    ins_src1,
    input  logic [INS_W-1:0]               ins_rdy1,
    input  logic [INS_W-1:0][TAG_W-1:0]    ins_src2,
    input  logic [INS_W-1:0]               ins_rdy2,
    input  logic [INS_W-1:0][TAG_W-1:0]    ins_dst,
    input  logic [INS_W-1:0][SEQ_W-1:0]    ins_seq,
    output logic                           ins_full,
    input  logic [WB_N-1:0]                wb_valid,
    input  logic [WB_N-1:0][TAG_W-1:0]     wb_tag,
    input  logic                           flush_valid,
    input  logic [SEQ_W-1:0]               flush_seq,
    output logic [ISSUE_W-1:0]             iss_valid,
    output logic [ISSUE_W-1:0][2:0]        iss_class,
    output logic [ISSUE_W-1:0][TAG_W-1:0]  iss_dst,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]  iss_seq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OFF_W = $clog2(INS_W + 1);

    dq_entry_t          q_r     [DEPTH];
    dq_entry_t          q_nxt   [DEPTH];
    dq_entry_t          ins_ent [INS_W];
    dq_entry_t          iss_ent [ISSUE_W];
    logic [CNT_W-1:0]   cnt_r;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [OFF_W-1:0]   offer;
    logic [DEPTH-1:0]   pick;
    logic               ins_take;

    // Backpressure from the occupancy before this cycle's issue.
    assign offer    = OFF_W'($countones(ins_valid));
    assign ins_full = (int'(DEPTH) - int'(cnt_r)) < int'(offer);
    assign ins_take = !flush_valid && !ins_full;

    always_comb begin
        for (int l = 0; l < INS_W; l++) begin
            ins_ent[l].vld  = ins_valid[l];
            ins_ent[l].cls  = op_class_e'(ins_class[l]);
            ins_ent[l].src1 = ins_src1[l];
            ins_ent[l].rdy1 = ins_rdy1[l];
            ins_ent[l].src2 = ins_src2[l];
            ins_ent[l].rdy2 = ins_rdy2[l];
            ins_ent[l].dst  = ins_dst[l];
            ins_ent[l].seq  = ins_seq[l];
        end
    end

    dq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_select (
        .ent       (q_r),
        .enable    (!flush_valid),
        .pick      (pick),
        .iss_valid (iss_valid),
        .iss_ent   (iss_ent)
    );

    dq_compact #(.DEPTH(DEPTH), .INS_W(INS_W), .WB_N(WB_N)) u_compact (
        .cur         (q_r),
        .pick        (pick),
        .flush_valid (flush_valid),
        .flush_seq   (flush_seq),
        .ins_ent     (ins_ent),
        .ins_take    (ins_take),
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .nxt         (q_nxt),
        .nxt_cnt     (cnt_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q_r[i] <= '0;
            cnt_r <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) q_r[i] <= q_nxt[i];
            cnt_r <= cnt_nxt;
        end
    end

    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            iss_class[s] = iss_ent[s].cls;
            iss_dst[s]   = iss_ent[s].dst;
            iss_seq[s]   = iss_ent[s].seq;
        end
    end

    // ---------------- assertions ----------------
    logic [ISSUE_W-1:0] fdiv_hit, ctrl_hit, mem_hit;
    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            fdiv_hit[s] = iss_valid[s] && iss_class[s] == CL_FDIV;
            ctrl_hit[s] = iss_valid[s] && iss_class[s] == CL_CTRL;
            mem_hit[s]  = iss_valid[s] && iss_class[s] == CL_MEM;
        end
    end

    assert_fdiv_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fdiv_hit) <= ISSUE_W / 4);
    assert_ctrl_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctrl_hit) <= ISSUE_W / 4);
    assert_mem_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_hit) <= ISSUE_W / 2);
    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> iss_valid == '0);
    assert_full_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_full |=> cnt_r <= $past(cnt_r));
    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_r) <= DEPTH);

    generate
        for (genvar s = 1; s < ISSUE_W; s++) begin : g_pack
            assert_slots_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[s] |-> iss_valid[s-1]);
        end
    endgenerate
endmodule

// File: tb/dq_unified_issue_tb.sv
`timescale 1ns/1ps
module dq_unified_issue_tb;
    import dq_pkg::*;

    localparam int DEPTH = 32;
    localparam int IW    = 4;
    localparam int INW   = 6;
    localparam int WBN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [INW-1:0]             ins_valid;
    logic [INW-1:0][2:0]        ins_class;
    logic [INW-1:0][TAG_W-1:0]  ins_src1, ins_src2, ins_dst;
    logic [INW-1:0]             ins_rdy1, ins_rdy2;
    logic [INW-1:0][SEQ_W-1:0]  ins_seq;
    logic                       ins_full;
    logic [WBN-1:0]             wb_valid;
    logic [WBN-1:0][TAG_W-1:0]  wb_tag;
    logic                       flush_valid;
    logic [SEQ_W-1:0]           flush_seq;
    logic [IW-1:0]              iss_valid;
    logic [IW-1:0][2:0]         iss_class;
    logic [IW-1:0][TAG_W-1:0]   iss_dst;
    logic [IW-1:0][SEQ_W-1:0]   iss_seq;

    dq_unified_issue #(.DEPTH(DEPTH), .ISSUE_W(IW), .WB_N(WBN)) u_dut (.*);

    typedef struct {
        bit [2:0] cls;
        bit [6:0] s1, s2, dst;
        bit       r1, r2;
        bit [7:0] seq;
    } m_t;

    m_t  mq[$];
    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit [7:0] next_seq = 8'd0;

    function automatic int bcap(input int c);
        case (c)
            0: return IW;
            1: return IW / 4;
            2: return IW / 2;
            3: return IW / 2;
            4: return IW / 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit byoung(input bit [7:0] a, input bit [7:0] b);
        bit [7:0] d;
        d = a - b;
        return d != 0 && d < 8'd128;
    endfunction

    function automatic m_t bwake(input m_t e);
        m_t r;
        r = e;
        for (int w = 0; w < WBN; w++) begin
            if (wb_valid[w] && wb_tag[w] == r.s1) r.r1 = 1'b1;
            if (wb_valid[w] && wb_tag[w] == r.s2) r.r2 = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ins_valid = '0; ins_class = '0; ins_src1 = '0; ins_src2 = '0;
        ins_dst = '0; ins_rdy1 = '0; ins_rdy2 = '0; ins_seq = '0;
        wb_valid = '0; wb_tag = '0; flush_valid = 1'b0; flush_seq = '0;
    endtask

    task automatic lane(input int l, input int c, input int s1, input bit r1,
                        input int s2, input bit r2, input int d);
        ins_valid[l] = 1'b1;
        ins_class[l] = 3'(c);
        ins_src1[l]  = 7'(s1); ins_rdy1[l] = r1;
        ins_src2[l]  = 7'(s2); ins_rdy2[l] = r2;
        ins_dst[l]   = 7'(d);
    endtask

    task automatic number_lanes();
        bit [7:0] s;
        s = next_seq;
        for (int l = 0; l < INW; l++) if (ins_valid[l]) begin ins_seq[l] = s; s++; end
    endtask

    // One cycle: compare outputs against the model, then advance both.
    task automatic step(input string req);
        bit [IW-1:0]     ev;
        bit [IW*18-1:0]  ef, af;
        int  used [5];
        int  tot;
        bit  pk [DEPTH];
        bit  full_e;
        m_t  nq[$];
        int  off;
        number_lanes();
        #1;
        ev = '0; ef = '0; af = '0; tot = 0;
        for (int c = 0; c < 5; c++) used[c] = 0;
        for (int i = 0; i < DEPTH; i++) pk[i] = 1'b0;
        for (int i = 0; i < mq.size(); i++) begin
            if (!flush_valid && mq[i].r1 && mq[i].r2 && tot < IW &&
                used[mq[i].cls] < bcap(int'(mq[i].cls))) begin
                pk[i] = 1'b1;
                ev[tot] = 1'b1;
                ef[tot*18 +: 18] = {mq[i].cls, mq[i].dst, mq[i].seq};
                used[mq[i].cls]++;
                tot++;
            end
        end
        for (int s = 0; s < IW; s++)
            if (iss_valid[s]) af[s*18 +: 18] = {iss_class[s], iss_dst[s], iss_seq[s]};
        check(iss_valid == ev && af == ef, req, "issue slots",
              {iss_valid, af}, {ev, ef});
        off = $countones(ins_valid);
        full_e = (DEPTH - mq.size()) < off;
        check(ins_full == full_e, req, "ins_full", 128'(ins_full), 128'(full_e));
        for (int i = 0; i < mq.size(); i++) begin
            if (!pk[i] && !(flush_valid && byoung(mq[i].seq, flush_seq)))
                nq.push_back(bwake(mq[i]));
        end
        if (!flush_valid && !full_e) begin
            for (int l = 0; l < INW; l++) if (ins_valid[l]) begin
                m_t e;
                e.cls = ins_class[l]; e.s1 = ins_src1[l]; e.s2 = ins_src2[l];
                e.r1 = ins_rdy1[l]; e.r2 = ins_rdy2[l]; e.dst = ins_dst[l];
                e.seq = ins_seq[l];
                nq.push_back(bwake(e));
            end
            next_seq = next_seq + 8'(off);
        end
        mq = nq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 12; k++) begin
            clear_inputs();
            for (int w = 0; w < WBN; w++) begin
                wb_valid[w] = 1'b1;
                wb_tag[w]   = 7'($urandom_range(0, 127));
            end
            step(req);
        end
        clear_inputs();
        for (int k = 0; k < 40 && mq.size() > 0; k++) begin
            flush_valid = 1'b1;
            flush_seq   = mq[0].seq - 8'd1;
            step(req);
        end
        clear_inputs();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1995));
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset, nothing issued, full low for a small offer
        check(iss_valid == '0, "R1", "iss_valid after reset", 128'(iss_valid), 128'(0));
        check(ins_full == 1'b0, "R1", "ins_full after reset", 128'(ins_full), 128'(0));
        @(negedge clk);

        // R2: gapped lanes appended in lane order
        clear_inputs();
        lane(0, 0, 1, 1, 2, 1, 10); lane(2, 0, 1, 1, 2, 1, 12);
        lane(3, 0, 1, 1, 2, 1, 13); lane(5, 0, 1, 1, 2, 1, 15);
        step("R2");
        clear_inputs();
        step("R2");
        step("R2");

        // R4: wakeup in the insertion cycle, and a later wakeup
        clear_inputs();
        lane(0, 0, 20, 0, 21, 1, 40);
        lane(1, 0, 22, 0, 23, 1, 41);
        wb_valid[0] = 1'b1; wb_tag[0] = 7'd20;
        step("R4");
        clear_inputs();
        step("R4");
        step("R4");
        wb_valid[1] = 1'b1; wb_tag[1] = 7'd22;
        step("R4");
        clear_inputs();
        step("R4");

        // R6: six ready integer ops, four then two
        clear_inputs();
        for (int l = 0; l < INW; l++) lane(l, 0, 3, 1, 4, 1, 50 + l);
        step("R6");
        clear_inputs();
        step("R6");
        step("R6");

        // R7: capped classes are skipped, younger work still issues
        clear_inputs();
        lane(0, 1, 3, 1, 4, 1, 60); lane(1, 1, 3, 1, 4, 1, 61);
        lane(2, 4, 3, 1, 4, 1, 62); lane(3, 4, 3, 1, 4, 1, 63);
        lane(4, 3, 3, 1, 4, 1, 64); lane(5, 0, 3, 1, 4, 1, 65);
        step("R7");
        clear_inputs();
        lane(0, 3, 3, 1, 4, 1, 66); lane(1, 3, 3, 1, 4, 1, 67);
        lane(2, 2, 3, 1, 4, 1, 68); lane(3, 2, 3, 1, 4, 1, 69);
        lane(4, 2, 3, 1, 4, 1, 70);
        step("R7");
        clear_inputs();
        for (int k = 0; k < 4; k++) step("R7");

        // R3 / R8: fill with sleeping ops, refuse, then reuse freed slots
        clear_inputs();
        for (int k = 0; k < 6; k++) begin
            for (int l = 0; l < INW; l++) lane(l, 0, 100, 0, 4, 1, 80 + l);
            step("R3");
        end
        clear_inputs();
        lane(0, 0, 100, 0, 4, 1, 90); lane(1, 0, 100, 0, 4, 1, 91);
        step("R3");
        clear_inputs();
        lane(0, 0, 100, 0, 4, 1, 92);
        step("R3");
        clear_inputs();
        wb_valid[0] = 1'b1; wb_tag[0] = 7'd100;
        step("R8");
        clear_inputs();
        for (int l = 0; l < 4; l++) lane(l, 0, 5, 1, 4, 1, 93 + l);
        step("R8");
        step("R8");

        // R9: flush with ready work and an offered insertion
        clear_inputs();
        lane(0, 0, 5, 1, 4, 1, 99);
        flush_valid = 1'b1; flush_seq = mq[10].seq;
        step("R9");
        clear_inputs();
        step("R9");
        drain("R9");

        // R5: constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            clear_inputs();
            for (int l = 0; l < INW; l++) begin
                if ($urandom_range(0, 1) == 1)
                    lane(l, $urandom_range(0, 4), $urandom_range(0, 15),
                         $urandom_range(0, 3) != 0, $urandom_range(0, 15),
                         $urandom_range(0, 3) != 0, $urandom_range(0, 127));
            end
            for (int w = 0; w < WBN; w++) begin
                wb_valid[w] = $urandom_range(0, 1) == 1;
                wb_tag[w]   = 7'($urandom_range(0, 15));
            end
            if (mq.size() > 0 && $urandom_range(0, 19) == 0) begin
                flush_valid = 1'b1;
                flush_seq   = mq[$urandom_range(0, mq.size() - 1)].seq;
            end
            step("R5");
        end
        done = 1'b1;
        finish_run();
    end
endmodule